// File: doc/BRIEF.md
# Exception Frame Sequencer

This block carries out the memory side of taking an exception and of returning from one. On a start pulse it captures the current status word, program counter and supervisor stack pointer. It moves the status word into supervisor state: trace is cleared, supervisor is set and, for interrupts only, the mask takes the accepted level. It then pushes a three-word context frame and fetches the handler address from the vector table. On a return command it pops the frame and restores the status word and program counter.

All traffic goes over one 16-bit word port. Each access is a request that is held steady until the memory acknowledges it. The handler address lives at the vector number times four. It is read as two words, the high word first. The frame has the saved status word at the final stack pointer, the upper half of the program counter two bytes above it and the lower half four bytes above it. A single-cycle done pulse marks the end of either operation.

Top module: `exc_seq`

## Requirements
- R1: After reset, busy_o, done_o, mem_req_o and mem_we_o are all low.
- R2: On the cycle after an accepted start, sr_o equals sr_i with bit 15 (trace) cleared and bit 13 (supervisor) set. Bits 10:8 (mask) take lvl_i only when irq_i is high. All other bits are kept.
- R3: Entry performs exactly three writes, in this order: sp_i-2 gets pc_i[15:0], sp_i-4 gets pc_i[31:16], and sp_i-6 gets the unmodified sr_i.
- R4: After an entry completes, sp_o equals sp_i-6.
- R5: After the pushes, entry reads byte address vec_i*4 and then vec_i*4+2. pc_o becomes {first word, second word}. This holds from vector 0 up to vector 255.
- R6: done_o is high for exactly one cycle, in the cycle after the final access is acknowledged. At that point busy_o is low and pc_o already holds its new value.
- R7: A return reads three words from addresses sp_i, sp_i+2 and sp_i+4 with no writes. These load sr_o, pc_o[31:16] and pc_o[15:0] in that order, and sp_o ends at sp_i+6.
- R8: While mem_req_o is high and mem_ack_i is low, mem_req_o, mem_we_o, mem_addr_o and mem_wdata_o hold their values into the next cycle.
- R9: start_i and ret_i are ignored while busy_o is high. The frame, the access count and the final pc_o all belong to the operation already running.
- R10: mem_req_o is low whenever busy_o is low. mem_we_o is high only together with mem_req_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin exception entry (sampled when idle) |
| ret_i | input | 1 | Begin return from exception (sampled when idle, start wins) |
| vec_i | input | 8 | Vector number |
| irq_i | input | 1 | Exception is an interrupt |
| lvl_i | input | 3 | Accepted interrupt level |
| sr_i | input | 16 | Current status word |
| pc_i | input | 32 | Program counter to save |
| sp_i | input | 32 | Supervisor stack pointer |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Access complete |
| sr_o | output | 16 | Updated or restored status word |
| pc_o | output | 32 | Handler or restored program counter |
| sp_o | output | 32 | Working and final stack pointer |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach from the ports is a second start or return that arrives while a sequence is stalled in the middle of an access. The bench's memory model holds the acknowledge back by a set number of cycles. It then raises start_i and ret_i, with different operands, during that stall. The bench then checks that the write log, the read addresses and the final pc_o all match the first operation only. The same stalled acknowledge also shows that the request stays unchanged while it waits.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int AW = 32;
  localparam int DW = 16;
  localparam int VW = 8;
  localparam int LW = 3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PUSH_PCL, ST_PUSH_PCH, ST_PUSH_SR,
    ST_VEC_HI, ST_VEC_LO, ST_POP_SR, ST_POP_PCH, ST_POP_PCL
  } seq_state_t;

  // status word on entry: trace off, supervisor on, mask only for interrupts
  function automatic logic [DW-1:0] sr_on_entry(input logic [DW-1:0] sr,
                                                input logic irq,
                                                input logic [LW-1:0] lvl);
    logic [DW-1:0] r;
    r = sr;
    r[15] = 1'b0;
    r[13] = 1'b1;
    if (irq) r[10:8] = lvl;
    return r;
  endfunction

  function automatic logic [AW-1:0] vec_to_addr(input logic [VW-1:0] vn);
    return {{(AW-VW-2){1'b0}}, vn, 2'b00};
  endfunction
endpackage

// File: rtl/exc_sr_mod.sv
module exc_sr_mod
  import exc_pkg::*;
(
  input  logic [DW-1:0] sr_in,
  input  logic          irq,
  input  logic [LW-1:0] lvl,
  output logic [DW-1:0] sr_out
);
  assign sr_out = sr_on_entry(sr_in, irq, lvl);
endmodule

// File: rtl/exc_port_mux.sv
module exc_port_mux
  import exc_pkg::*;
(
  input  seq_state_t    state,
  input  logic [AW-1:0] sp,
  input  logic [AW-1:0] vaddr,
  input  logic [31:0]   pc_save,
  input  logic [DW-1:0] sr_save,
  output logic          req,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata
);
  localparam logic [AW-1:0] STEP = AW'(2);

  always_comb begin
    req   = 1'b1;
    we    = 1'b0;
    addr  = sp;
    wdata = '0;
    unique case (state)
      ST_PUSH_PCL: begin we = 1'b1; addr = sp - STEP; wdata = pc_save[15:0];  end
      ST_PUSH_PCH: begin we = 1'b1; addr = sp - STEP; wdata = pc_save[31:16]; end
      ST_PUSH_SR:  begin we = 1'b1; addr = sp - STEP; wdata = sr_save;        end
      ST_VEC_HI:   addr = vaddr;
      ST_VEC_LO:   addr = vaddr + STEP;
      ST_POP_SR, ST_POP_PCH, ST_POP_PCL: addr = sp;
      default:     req = 1'b0;
    endcase
  end
endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          ret_i,
  input  logic [7:0]    vec_i,
  input  logic          irq_i,
  input  logic [2:0]    lvl_i,
  input  logic [15:0]   sr_i,
  input  logic [31:0]   pc_i,
  input  logic [31:0]   sp_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [31:0]   mem_addr_o,
  output logic [15:0]   mem_wdata_o,
  input  logic [15:0]   mem_rdata_i,
  input  logic          mem_ack_i,
  output logic [15:0]   sr_o,
  output logic [31:0]   pc_o,
  output logic [31:0]   sp_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam logic [AW-1:0] STEP = AW'(2);

  seq_state_t    state;
  logic [DW-1:0] sr_q, sr_save, sr_new;
  logic [31:0]   pc_q, pc_save;
  logic [AW-1:0] sp_q, vaddr_q;
  logic [DW-1:0] hi_q;
  logic          done_q;

  // named events for the checker
  logic entry_go, exit_go, acc_done;
  assign entry_go = (state == ST_IDLE) && start_i;
  assign exit_go  = (state == ST_IDLE) && !start_i && ret_i;
  assign acc_done = mem_req_o && mem_ack_i;

  exc_sr_mod u_sr (.sr_in(sr_i), .irq(irq_i), .lvl(lvl_i), .sr_out(sr_new));

  exc_port_mux u_mux (
    .state(state), .sp(sp_q), .vaddr(vaddr_q), .pc_save(pc_save),
    .sr_save(sr_save), .req(mem_req_o), .we(mem_we_o),
    .addr(mem_addr_o), .wdata(mem_wdata_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sr_q    <= '0;
      sr_save <= '0;
      pc_q    <= '0;
      pc_save <= '0;
      sp_q    <= '0;
      vaddr_q <= '0;
      hi_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (entry_go) begin
            sr_save <= sr_i;
            sr_q    <= sr_new;
            pc_save <= pc_i;
            sp_q    <= sp_i;
            vaddr_q <= vec_to_addr(vec_i);
            state   <= ST_PUSH_PCL;
          end else if (exit_go) begin
            sp_q  <= sp_i;
            state <= ST_POP_SR;
          end
        end
        ST_PUSH_PCL: if (acc_done) begin sp_q <= sp_q - STEP; state <= ST_PUSH_PCH; end
        ST_PUSH_PCH: if (acc_done) begin sp_q <= sp_q - STEP; state <= ST_PUSH_SR;  end
        ST_PUSH_SR:  if (acc_done) begin sp_q <= sp_q - STEP; state <= ST_VEC_HI;   end
        ST_VEC_HI:   if (acc_done) begin hi_q <= mem_rdata_i; state <= ST_VEC_LO;   end
        ST_VEC_LO: if (acc_done) begin
          pc_q   <= {hi_q, mem_rdata_i};
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        ST_POP_SR: if (acc_done) begin
          sr_q <= mem_rdata_i; sp_q <= sp_q + STEP; state <= ST_POP_PCH;
        end
        ST_POP_PCH: if (acc_done) begin
          hi_q <= mem_rdata_i; sp_q <= sp_q + STEP; state <= ST_POP_PCL;
        end
        ST_POP_PCL: if (acc_done) begin
          pc_q   <= {hi_q, mem_rdata_i};
          sp_q   <= sp_q + STEP;
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sr_o   = sr_q;
  assign pc_o   = pc_q;
  assign sp_o   = sp_q;
  assign busy_o = (state != ST_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        req,
  input logic        we,
  input logic        ack,
  input logic [31:0] addr,
  input logic [15:0] wdata,
  input logic [15:0] sr,
  input logic        entry_go,
  input logic        exit_go
);
  assert_sr_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    entry_go |=> (sr[13] && !sr[15]));
  assert_first_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    entry_go |=> (req && we));
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_pop_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exit_go |=> (req && !we));
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> (req && $stable(we) && $stable(addr) && $stable(wdata)));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req);
  assert_we_in_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> req);
endmodule

bind exc_seq exc_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_o), .done(done_o), .req(mem_req_o),
  .we(mem_we_o), .ack(mem_ack_i), .addr(mem_addr_o), .wdata(mem_wdata_o),
  .sr(sr_o), .entry_go(entry_go), .exit_go(exit_go)
);

// File: tb/sim_exc_seq.sv
`timescale 1ns/1ps
module sim_exc_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, ret_i = 1'b0, irq_i = 1'b0;
  logic [7:0]  vec_i = '0;
  logic [2:0]  lvl_i = '0;
  logic [15:0] sr_i = '0;
  logic [31:0] pc_i = '0, sp_i = '0;
  logic        mem_req_o, mem_we_o, mem_ack_i = 1'b0;
  logic [31:0] mem_addr_o;
  logic [15:0] mem_wdata_o, mem_rdata_i = '0;
  logic [15:0] sr_o;
  logic [31:0] pc_o, sp_o;
  logic        busy_o, done_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  exc_seq u0 (.*);

  // memory model with programmable acknowledge delay
  logic [15:0] mem [logic [31:0]];
  int          ack_delay = 0;
  int          wait_cnt = 0;
  logic [31:0] wr_a [0:7];
  logic [15:0] wr_d [0:7];
  logic [31:0] rd_a [0:7];
  int          wr_n = 0, rd_n = 0;
  int          stall_seen = 0;

  always @(negedge clk) begin
    if (mem_ack_i) begin
      mem_ack_i = 1'b0;
      wait_cnt  = 0;
    end else if (mem_req_o) begin
      if (wait_cnt >= ack_delay) begin
        mem_ack_i = 1'b1;
        if (mem_we_o) begin
          mem[mem_addr_o] = mem_wdata_o;
          if (wr_n < 8) begin wr_a[wr_n] = mem_addr_o; wr_d[wr_n] = mem_wdata_o; end
          wr_n++;
        end else begin
          mem_rdata_i = mem.exists(mem_addr_o) ? mem[mem_addr_o] : 16'h0000;
          if (rd_n < 8) rd_a[rd_n] = mem_addr_o;
          rd_n++;
        end
      end else begin
        wait_cnt++;
        stall_seen++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model_sr(input logic [15:0] s, input logic irq,
                                           input logic [2:0] l);
    logic [15:0] t;
    t = (s & 16'h5FFF) | 16'h2000;
    if (irq) t = (t & 16'hF8FF) | ({13'd0, l} << 8);
    return t;
  endfunction

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done_o && n < 300) begin @(negedge clk); n++; end
    chk(n < 300, {tag, " timeout"}, n, 300);
  endtask

  task automatic run_entry(input logic [15:0] s, input logic [31:0] pc,
                           input logic [31:0] sp, input logic [7:0] v,
                           input logic irq, input logic [2:0] l, input int dly,
                           input logic [15:0] vh, input logic [15:0] vl,
                           input bit disturb);
    logic [31:0] va;
    va = {22'd0, v, 2'b00};
    mem[va] = vh;
    mem[va + 32'd2] = vl;
    ack_delay = dly; wr_n = 0; rd_n = 0;
    @(negedge clk);
    sr_i = s; pc_i = pc; sp_i = sp; vec_i = v; irq_i = irq; lvl_i = l;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R2: sr_o updated one cycle after start
    chk(sr_o == model_sr(s, irq, l), "R2 sr on entry", sr_o, model_sr(s, irq, l));
    if (disturb) begin
      @(negedge clk);
      sr_i = 16'hFFFF; pc_i = 32'hDEAD_BEEF; sp_i = 32'h100; vec_i = 8'h11;
      start_i = 1'b1; ret_i = 1'b1;
      @(negedge clk);
      @(negedge clk);
      start_i = 1'b0; ret_i = 1'b0;
    end
    wait_done("R6 entry");
    chk(!busy_o, "R6 busy low at done", busy_o, 0);
    chk(wr_n == 3, "R3 write count", wr_n, 3);
    chk(wr_a[0] == sp - 2 && wr_d[0] == pc[15:0],  "R3 word PC low",  wr_a[0], sp - 2);
    chk(wr_a[1] == sp - 4 && wr_d[1] == pc[31:16], "R3 word PC high", wr_a[1], sp - 4);
    chk(wr_a[2] == sp - 6 && wr_d[2] == s,         "R3 word SR",      {16'd0, wr_d[2]}, {16'd0, s});
    chk(sp_o == sp - 6, "R4 final sp", sp_o, sp - 6);
    chk(rd_n == 2 && rd_a[0] == va && rd_a[1] == va + 2, "R5 vector reads", rd_a[0], va);
    chk(pc_o == {vh, vl}, "R5 handler pc", pc_o, {vh, vl});
    if (disturb) chk(pc_o == {vh, vl} && wr_n == 3, "R9 busy start ignored", pc_o, {vh, vl});
    @(negedge clk);
    chk(!done_o, "R6 done one cycle", done_o, 0);
    chk(!mem_req_o && !mem_we_o, "R10 idle no request", mem_req_o, 0);
  endtask

  task automatic run_return(input logic [31:0] sp, input logic [15:0] es,
                            input logic [31:0] epc, input int dly);
    ack_delay = dly; wr_n = 0; rd_n = 0;
    @(negedge clk);
    sp_i = sp; ret_i = 1'b1;
    @(negedge clk);
    ret_i = 1'b0;
    wait_done("R6 return");
    chk(wr_n == 0, "R7 no writes", wr_n, 0);
    chk(rd_n == 3 && rd_a[0] == sp && rd_a[1] == sp + 2 && rd_a[2] == sp + 4,
        "R7 pop addresses", rd_a[0], sp);
    chk(sr_o == es, "R7 sr restored", sr_o, es);
    chk(pc_o == epc, "R7 pc restored", pc_o, epc);
    chk(sp_o == sp + 6, "R7 sp after return", sp_o, sp + 6);
    @(negedge clk);
    chk(!done_o, "R6 done one cycle after return", done_o, 0);
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy_o && !done_o && !mem_req_o && !mem_we_o, "R1 reset outputs",
        {busy_o, done_o, mem_req_o, mem_we_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !mem_req_o, "R1 idle after reset", busy_o, 0);

    // non-interrupt: trace set, level input must not reach mask (R2)
    run_entry(16'h8016, 32'h0000_1040, 32'h0000_4000, 8'd5, 1'b0, 3'd3, 0,
              16'h0040, 16'h0800, 1'b0);
    // return from that frame (R7)
    run_return(32'h0000_3FFA, 16'h8016, 32'h0000_1040, 1);
    // interrupt, mask replaced, slow memory (R2, R8)
    stall_seen = 0;
    run_entry(16'h0315, 32'h00AB_CDEF, 32'h0000_2000, 8'd29, 1'b1, 3'd5, 3,
              16'h0012, 16'h3456, 1'b0);
    chk(stall_seen > 0, "R8 stalls exercised", stall_seen, 1);
    // highest vector, level 7 (R5)
    run_entry(16'hA7FF, 32'h1234_5678, 32'h0000_1000, 8'd255, 1'b1, 3'd7, 0,
              16'hFEDC, 16'hBA98, 1'b0);
    // vector zero (R5)
    run_entry(16'h0000, 32'h0000_0002, 32'h0000_0800, 8'd0, 1'b0, 3'd0, 0,
              16'h0000, 16'h0400, 1'b0);
    // new start and return while busy (R9)
    run_entry(16'h2004, 32'h0007_0000, 32'h0000_3000, 8'd9, 1'b0, 3'd0, 4,
              16'h0055, 16'hAA00, 1'b1);
    run_return(32'h0000_2FFA, 16'h2004, 32'h0007_0000, 2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule